// File: doc/BRIEF.md
# Per-Port Input Debounce Filter

This block sits between eight raw input pins of one port and whatever samples them (the input register and the interrupt detector). Each pin can be switched between a direct path and a filtered path. A filtered pin moves its output to a new level only after its raw input has held that level, without a break, for a programmed number of millisecond ticks. A single 8-bit count register sets that number of ticks for every pin of the port. Each pin still keeps its own stability timer, so pins settle independently of one another.

Software programs the block through a small synchronous register bus. The count register is written directly. The per-pin enables are written through a masked alias: the upper byte selects which enable bits to touch, and the lower byte gives their new values, so one pin can be changed without a read-modify-write. An internal prescaler divides the system clock down to a millisecond tick. A count of zero turns filtering off for the whole port.

Top module: `port_debounce`

## Requirements
- R1: After synchronous reset the count register, all enables, all filtered outputs and the read data are 0.
- R2: An internal tick occurs once every CLK_HZ/TICK_HZ clocks. The first tick falls on the N-th rising edge after reset is released, where N is that ratio.
- R3: A filtered pin (enable 1 and count non-zero) updates its output to the raw level at the count-th tick edge. Ticks are counted from the moment the raw level starts to differ from the output. The output never changes on an edge that is not a tick edge.
- R4: An unfiltered pin (enable 0, or count 0) copies its raw input to the output with one clock of latency.
- R5: A write to address 0x0 loads bits 7:0 into the count register, which all eight pins share. The register does not change without such a write.
- R6: A write to address 0x4 updates enable bit i to data bit i only where data bit 8+i is 1. Enable bits whose mask bit is 0 keep their value.
- R7: A read request registers the read data one clock later: address 0x0 returns the count, address 0x8 returns the enables, and any other address returns 0. Without a read request the read data holds its value.
- R8: If the count is lowered below the ticks already seen by a pending pin, the pin releases at the next tick edge.
- R9: If a pin's enable is cleared while a change is pending, its output follows the raw input one clock after the enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_rd | input | 1 | Read strobe for the register bus |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_raw | input | PINS | Raw pin levels, already synchronous to clk |
| pin_filt | output | PINS | Debounced pin levels |

## Verification
The bench builds the block with CLK_HZ=4000 and TICK_HZ=1000, so one tick arrives every four clocks. With that setting the largest count of 255 settles in about a thousand cycles. It also puts the tick phase, glitches that are one tick too short, and a count lowered mid-wait within a few cycles of each other. Random bouncing on all pins, combined with random counts from 0 to 4 and random masked enable writes, mixes the direct and filtered paths on the same port at once.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  // Register byte offsets inside the port window
  localparam int unsigned OFS_COUNT     = 0;
  localparam int unsigned OFS_EN_MASKED = 4;
  localparam int unsigned OFS_EN_VIEW   = 8;

  // Number of clocks per tick, never below one
  function automatic int unsigned tick_div(input int unsigned clk_hz, input int unsigned tick_hz);
    int unsigned d;
    d = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
    return (d == 0) ? 1 : d;
  endfunction
endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PC_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign tick = 1'b1;
    end else begin : g_div
      logic [PC_W-1:0] pc_q;
      logic            wrap;
      assign wrap = (pc_q == PC_W'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (wrap) pc_q <= '0;
        else           pc_q <= pc_q + 1'b1;
      end
      assign tick = wrap;
    end
  endgenerate
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs
  import dbnc_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [PINS-1:0]   en_q
);
  logic [PINS-1:0] wmask, wval;
  logic            hit_cnt, hit_msk, hit_view;

  assign wval     = wdata[PINS-1:0];
  assign wmask    = wdata[2*PINS-1:PINS];
  assign hit_cnt  = (addr == ADDR_W'(OFS_COUNT));
  assign hit_msk  = (addr == ADDR_W'(OFS_EN_MASKED));
  assign hit_view = (addr == ADDR_W'(OFS_EN_VIEW));

  generate
    if (DATA_W > 2*PINS) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:2*PINS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      if (hit_cnt)      cnt_q <= wdata[CNT_W-1:0];
      else if (hit_msk) en_q  <= (en_q & ~wmask) | (wval & wmask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (hit_cnt)       rdata <= DATA_W'(cnt_q);
      else if (hit_view) rdata <= DATA_W'(en_q);
      else               rdata <= '0;
    end
  end
endmodule

// File: rtl/dbnc_pin.sv
module dbnc_pin #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  output logic             out_q
);
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W:0]   tmr_inc;
  logic             settled;

  assign tmr_inc = {1'b0, tmr_q} + (CNT_W+1)'(1);
  assign settled = (tmr_inc >= {1'b0, cnt});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      tmr_q <= '0;
    end else if (!filt_en) begin
      out_q <= raw;
      tmr_q <= '0;
    end else if (raw == out_q) begin
      tmr_q <= '0;
    end else if (tick) begin
      if (settled) begin
        out_q <= raw;
        tmr_q <= '0;
      end else begin
        tmr_q <= tmr_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/port_debounce.sv
module port_debounce
  import dbnc_pkg::*;
#(
  parameter int unsigned PINS    = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_raw,
  output logic [PINS-1:0]   pin_filt
);
  localparam int unsigned TICK_DIV = tick_div(CLK_HZ, TICK_HZ);

  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [PINS-1:0]  en_q;
  logic [PINS-1:0]  filt_mask;

  dbnc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dbnc_regs #(
    .PINS   (PINS),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr),
    .rd_en (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cnt_q (cnt_q),
    .en_q  (en_q)
  );

  assign filt_mask = en_q & {PINS{cnt_q != '0}};

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      dbnc_pin #(.CNT_W(CNT_W)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .raw     (pin_raw[i]),
        .filt_en (filt_mask[i]),
        .cnt     (cnt_q),
        .tick    (tick),
        .out_q   (pin_filt[i])
      );
    end
  endgenerate
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker
  import dbnc_pkg::*;
#(
  parameter int unsigned PINS     = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned TICK_DIV = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pin_raw,
  input logic [PINS-1:0]   pin_filt,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PINS-1:0]   en_q,
  input logic              tick
);
  logic [PINS-1:0] fmask;
  logic [PINS-1:0] wmask;
  logic            wr_cnt, wr_msk;

  assign fmask  = en_q & {PINS{cnt_q != '0}};
  assign wmask  = bus_wdata[2*PINS-1:PINS];
  assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_msk = bus_wr && (bus_addr == ADDR_W'(OFS_EN_MASKED));

  generate
    if (TICK_DIV > 1) begin : g_tick_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate

  AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (((pin_filt ^ $past(pin_filt)) & $past(fmask)) != '0)) |-> $past(tick)); // R3

  AST_UNFILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_filt & ~$past(fmask)) == ($past(pin_raw) & ~$past(fmask)))); // R4

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_cnt) |-> $stable(cnt_q)); // R5

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
    $past(wr_msk) |-> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask)))); // R6

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R7
endmodule

bind port_debounce dbnc_checker #(
  .PINS     (PINS),
  .CNT_W    (CNT_W),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .TICK_DIV (TICK_DIV)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_raw   (pin_raw),
  .pin_filt  (pin_filt),
  .cnt_q     (cnt_q),
  .en_q      (en_q),
  .tick      (tick)
);

// File: tb/tb_port_debounce.sv
module tb_port_debounce;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_raw = '0;
  logic [7:0]  pin_filt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit chk_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_debounce #(
    .PINS(8), .CNT_W(8), .DATA_W(32), .ADDR_W(4), .CLK_HZ(4000), .TICK_HZ(1000)
  ) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  // Reference model built from the requirements
  int          m_pc;
  bit          m_tick;
  logic [7:0]  m_cnt, m_en, m_out;
  int          m_tmr [8];
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_pc <= 0; m_cnt <= '0; m_en <= '0; m_out <= '0; m_rd <= '0;
      for (int i = 0; i < 8; i++) m_tmr[i] <= 0;
    end else begin
      m_tick = (m_pc == P-1);
      m_pc <= m_tick ? 0 : m_pc + 1;
      if (bus_wr && bus_addr == 4'h0) m_cnt <= bus_wdata[7:0];
      if (bus_wr && bus_addr == 4'h4)
        m_en <= (m_en & ~bus_wdata[15:8]) | (bus_wdata[7:0] & bus_wdata[15:8]);
      if (bus_rd) m_rd <= (bus_addr == 4'h0) ? {24'h0, m_cnt} :
                          (bus_addr == 4'h8) ? {24'h0, m_en} : 32'h0;
      for (int i = 0; i < 8; i++) begin
        if (!(m_en[i] && m_cnt != 0)) begin
          m_out[i] <= pin_raw[i]; m_tmr[i] <= 0;
        end else if (pin_raw[i] == m_out[i]) begin
          m_tmr[i] <= 0;
        end else if (m_tick) begin
          if (m_tmr[i] + 1 >= int'(m_cnt)) begin m_out[i] <= pin_raw[i]; m_tmr[i] <= 0; end
          else m_tmr[i] <= m_tmr[i] + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      for (int i = 0; i < 8; i++) begin
        n_chk++;
        if (pin_filt[i] !== m_out[i]) begin
          n_fail++;
          $display("FAIL %s pin%0d actual=%0b expected=%0b",
                   (m_en[i] && m_cnt != 0) ? "R3" : "R4", i, pin_filt[i], m_out[i]);
        end
      end
      n_chk++;
      if (bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R7 rdata actual=%h expected=%h", bus_rdata, m_rd);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_change(input int idx, input int maxc, output int n);
    logic ref_v;
    ref_v = pin_filt[idx];
    n = 0;
    while (n < maxc) begin
      @(negedge clk); n++;
      if (pin_filt[idx] !== ref_v) break;
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] hold;
    int n;
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 filt in reset", {24'h0, pin_filt}, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    chk_on = 1'b1;
    bus_read(4'h0, rd); check("R1 count after reset", rd, 32'h0);
    bus_read(4'h8, rd); check("R1 enables after reset", rd, 32'h0);
    // R7: unknown address reads 0, rdata holds with no read
    bus_read(4'hC, rd); check("R7 unknown addr", rd, 32'h0);
    bus_read(4'h4, rd); check("R7 alias addr reads 0", rd, 32'h0);
    // R4: count 0 passes through even with all enables set
    bus_write(4'h4, 32'h0000_FFFF);
    pin_raw = 8'hA5;
    repeat (2) @(negedge clk);
    check("R4 count zero passthrough", {24'h0, pin_filt}, 32'h0000_00A5);
    // R5, R6: shared count and masked enable write
    bus_write(4'h0, 32'hFFFF_FF03);
    bus_write(4'h4, 32'h0000_F030);
    bus_read(4'h8, rd); check("R6 masked enable", rd, 32'h0000_003F);
    bus_read(4'h0, rd); check("R5 count readback", rd, 32'h0000_0003);
    hold = bus_rdata;
    repeat (3) @(negedge clk);
    check("R7 rdata holds", bus_rdata, hold);
    // R3: glitch one tick short does not pass
    pin_raw[0] = 1'b0;
    for (int k = 0; k < 2*P; k++) begin
      @(negedge clk);
      check("R3 short glitch blocked", {31'h0, pin_filt[0]}, 32'h1);
    end
    pin_raw[0] = 1'b1;
    @(negedge clk);
    // R3 R2: held change releases at third tick; unfiltered pin7 follows at once
    pin_raw[0] = 1'b0; pin_raw[7] = 1'b0;
    @(negedge clk);
    check("R4 unfiltered pin7 next cycle", {31'h0, pin_filt[7]}, 32'h0);
    wait_change(0, 3*P+4, n);
    n = n + 1;
    check("R3 R2 release not early", {31'h0, (n >= 2*P+1)}, 32'h1);
    check("R3 R2 release not late", {31'h0, (n <= 3*P)}, 32'h1);
    // R8: lowering the count releases a pending pin at the next tick
    bus_write(4'h0, 32'h0000_00FF);
    pin_raw[1] = 1'b1;
    repeat (20) @(negedge clk);
    check("R3 count 255 still waiting", {31'h0, pin_filt[1]}, 32'h0);
    bus_write(4'h0, 32'h0000_0002);
    wait_change(1, P+2, n);
    check("R8 release after count lowered", {31'h0, pin_filt[1]}, 32'h1);
    check("R8 release within one tick", {31'h0, (n <= P)}, 32'h1);
    // R9: clearing an enable mid-wait lets the pin follow
    bus_write(4'h0, 32'h0000_00FF);
    pin_raw[2] = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 pin2 held", {31'h0, pin_filt[2]}, 32'h1);
    bus_write(4'h4, 32'h0000_0400);
    @(negedge clk);
    check("R9 disabled pin follows", {31'h0, pin_filt[2]}, 32'h0);
    bus_read(4'h8, rd); check("R6 only bit2 cleared", rd, 32'h0000_003B);
    // Random phase against the reference model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      for (int b = 0; b < 8; b++)
        if ($urandom_range(0, 7) == 0) pin_raw[b] = ~pin_raw[b];
      case ($urandom_range(0, 19))
        0: begin bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = {$urandom} & 32'hFFFF_FF00 | 32'($urandom_range(0, 4)); end
        1: begin bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = $urandom; end
        2: begin bus_rd = 1'b1; bus_addr = 4'($urandom_range(0, 15)); end
        default: ;
      endcase
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule